// File: doc/BRIEF.md
# DSI Horizontal Timing Calculator

This block turns a parallel-pixel horizontal timing description into the byte and byte-clock values that a DSI transmitter needs for sync-pulse video mode. The timing description gives the sync width, back porch, active width and front porch in pixel clocks. The block also takes the bits per pixel and the number of lanes. From these it produces four packet payload sizes, each with its fixed packet-overhead correction already subtracted. It also produces the total line length in byte clocks, the payload of the long blanking packet, and the idle duration used on lines that carry no pixels.

A one-cycle `start` pulse captures the inputs while the block is idle. A three-stage sequence then computes the results: capture, byte conversion, then totals. The results appear together with a one-cycle `done` pulse and stay unchanged until the next computation finishes. If the configuration is illegal, the block raises `cfgErr` and forces every numeric result to zero.

Top module: `dsi_htiming_calc`

## Requirements
- R1: For each timing field, "bytes" means floor(pixels × bpp / 8). The results are: syncPayload = sync bytes − 14, backPayload = back bytes − 12, activePayload = active bytes, and frontPayload = front bytes − 6.
- R2: lineLen = ceil(lineBytes / lanes), where lineBytes = floor((sync + back + active + front) × bpp / 8).
- R3: blankPayload = lineBytes − 20 − syncPayload.
- R4: idleLen = lineLen − ceil(sync bytes / lanes). The same value serves both regular blank lines and vertical blanking lines.
- R5: `cfgErr` is set when bpp is not 16, 18, 24 or 30. It is also set when the lane count is outside 1 to 4.
- R6: `cfgErr` is set when active × bpp is not a multiple of 32, that is, when the active bytes are not whole 32-bit words.
- R7: `cfgErr` is set when any corrected payload would be negative (sync bytes < 14, back bytes < 12, front bytes < 6). At 24 bpp it is also set when sync < 5, back < 5 or front < 10 pixels. While `cfgErr` is 1, all seven numeric outputs are 0.
- R8: A `start` sampled while idle captures all inputs. `busy` is then high for the next two cycles. `done` is high for exactly one cycle, the third cycle after the capture edge, and the results change in that same cycle. Inputs may change after capture without effect.
- R9: A `start` sampled while `busy` is 1 is ignored. A `start` sampled in the `done` cycle is accepted. All results and `cfgErr` hold their values in every cycle in which `done` is 0.
- R10: After reset, `busy`, `done`, `cfgErr` and all numeric outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a computation (taken only while idle) |
| syncPix | input | 16 | Horizontal sync width in pixel clocks |
| backPix | input | 16 | Horizontal back porch in pixel clocks |
| activePix | input | 16 | Active pixels per line |
| frontPix | input | 16 | Horizontal front porch in pixel clocks |
| bpp | input | 6 | Bits per pixel |
| lanes | input | 3 | Number of data lanes |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle pulse when results update |
| cfgErr | output | 1 | Illegal configuration |
| syncPayload | output | 20 | Sync-width packet payload in bytes |
| backPayload | output | 20 | Back-porch packet payload in bytes |
| activePayload | output | 20 | Active pixel payload in bytes |
| frontPayload | output | 20 | Front-porch packet payload in bytes |
| lineLen | output | 20 | Line length in byte clocks |
| blankPayload | output | 20 | Blanking long-packet payload in bytes |
| idleLen | output | 20 | Idle duration in byte clocks on pixel-free lines |

## Verification
Each stage holds its state in a single register set. A wrong capture or a wrong byte-conversion register therefore shows up as a wrong payload, line length or error flag in the `done` cycle itself. A wrong sequencer state shows up sooner: `busy` or `done` would be off one cycle after the faulty edge. Results that drift between pulses would violate the hold rule at the very next cycle. The bench therefore compares every output on every clock against a behavioural model, so a divergence is reported at most three cycles after the stimulus that caused it.

// File: rtl/htc_pkg.sv
package htc_pkg;
  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic capture;     // latch inputs
    logic calcBytes;   // pixel-to-byte conversion and legality
    logic calcTotals;  // totals, corrections, commit to outputs
  } htcStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BYTES = 2'd1,
    ST_TOTAL = 2'd2
  } htcState_e;
endpackage

// File: rtl/htc_ctrl.sv
module htc_ctrl
  import htc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output htcStrobes_t strb,
  output logic        busy,
  output logic        done
);
  htcState_e state;

  always_comb begin
    strb.capture    = (state == ST_IDLE) && start;
    strb.calcBytes  = (state == ST_BYTES);
    strb.calcTotals = (state == ST_TOTAL);
    busy            = (state != ST_IDLE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      done <= strb.calcTotals;
      unique case (state)
        ST_IDLE:  if (start) state <= ST_BYTES;
        ST_BYTES: state <= ST_TOTAL;
        ST_TOTAL: state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/htc_datapath.sv
module htc_datapath
  import htc_pkg::*;
#(
  parameter int PIX_W  = 16,
  parameter int BPP_W  = 6,
  parameter int LANE_W = 3,
  parameter int OUT_W  = PIX_W + 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  htcStrobes_t       strb,
  input  logic [PIX_W-1:0]  syncPix,
  input  logic [PIX_W-1:0]  backPix,
  input  logic [PIX_W-1:0]  activePix,
  input  logic [PIX_W-1:0]  frontPix,
  input  logic [BPP_W-1:0]  bpp,
  input  logic [LANE_W-1:0] lanes,
  output logic              cfgErr,
  output logic [OUT_W-1:0]  syncPayload,
  output logic [OUT_W-1:0]  backPayload,
  output logic [OUT_W-1:0]  activePayload,
  output logic [OUT_W-1:0]  frontPayload,
  output logic [OUT_W-1:0]  lineLen,
  output logic [OUT_W-1:0]  blankPayload,
  output logic [OUT_W-1:0]  idleLen
);
  localparam int NCH    = 4;            // sync, back, active, front
  localparam int SUM_W  = PIX_W + 2;
  localparam int PROD_W = SUM_W + BPP_W;
  localparam int CH_SYNC = 0, CH_BACK = 1, CH_ACT = 2, CH_FRONT = 3;

  logic [PIX_W-1:0]  capPix [NCH];
  logic [BPP_W-1:0]  capBpp;
  logic [LANE_W-1:0] capLanes;
  logic [OUT_W-1:0]  byteNow [NCH];
  logic [OUT_W-1:0]  byteReg [NCH];
  logic [PROD_W-1:0] chanProd [NCH];
  logic [OUT_W-1:0]  lineBytes;
  logic              errReg;

  function automatic logic [OUT_W-1:0] ceilDiv(input logic [OUT_W-1:0] x,
                                               input logic [LANE_W-1:0] n);
    logic [OUT_W:0] xe;
    xe = {1'b0, x};
    if (n == LANE_W'(1))      ceilDiv = x;
    else if (n == LANE_W'(2)) ceilDiv = OUT_W'((xe + (OUT_W+1)'(1)) >> 1);
    else if (n == LANE_W'(3)) ceilDiv = OUT_W'((xe + (OUT_W+1)'(2)) / (OUT_W+1)'(3));
    else if (n == LANE_W'(4)) ceilDiv = OUT_W'((xe + (OUT_W+1)'(3)) >> 2);
    else                      ceilDiv = '0;
  endfunction

  // Per-channel pixel-to-byte converters
  for (genvar i = 0; i < NCH; i++) begin : g_chan
    assign chanProd[i] = PROD_W'(capPix[i]) * PROD_W'(capBpp);
    assign byteNow[i]  = OUT_W'(chanProd[i] >> 3);
  end

  logic [SUM_W-1:0]  pixSum;
  logic [PROD_W-1:0] lineProd;
  logic              bppBad, lanesBad, misAlign, tooShort, rgbShort;

  always_comb begin
    pixSum   = SUM_W'(capPix[CH_SYNC]) + SUM_W'(capPix[CH_BACK])
             + SUM_W'(capPix[CH_ACT])  + SUM_W'(capPix[CH_FRONT]);
    lineProd = PROD_W'(pixSum) * PROD_W'(capBpp);
    bppBad   = !((capBpp == BPP_W'(16)) || (capBpp == BPP_W'(18)) ||
                 (capBpp == BPP_W'(24)) || (capBpp == BPP_W'(30)));
    lanesBad = (capLanes == '0) || (capLanes > LANE_W'(4));
    misAlign = (chanProd[CH_ACT][4:0] != 5'd0);
    tooShort = (byteNow[CH_SYNC] < OUT_W'(14)) || (byteNow[CH_BACK] < OUT_W'(12)) ||
               (byteNow[CH_FRONT] < OUT_W'(6));
    rgbShort = (capBpp == BPP_W'(24)) &&
               ((capPix[CH_SYNC] < PIX_W'(5)) || (capPix[CH_BACK] < PIX_W'(5)) ||
                (capPix[CH_FRONT] < PIX_W'(10)));
  end

  logic [OUT_W-1:0] lineLenNow, syncCeil;
  always_comb begin
    lineLenNow = ceilDiv(lineBytes, capLanes);
    syncCeil   = ceilDiv(byteReg[CH_SYNC], capLanes);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NCH; i++) begin
        capPix[i]  <= '0;
        byteReg[i] <= '0;
      end
      capBpp        <= '0;
      capLanes      <= '0;
      lineBytes     <= '0;
      errReg        <= 1'b0;
      cfgErr        <= 1'b0;
      syncPayload   <= '0;
      backPayload   <= '0;
      activePayload <= '0;
      frontPayload  <= '0;
      lineLen       <= '0;
      blankPayload  <= '0;
      idleLen       <= '0;
    end else begin
      if (strb.capture) begin
        capPix[CH_SYNC]  <= syncPix;
        capPix[CH_BACK]  <= backPix;
        capPix[CH_ACT]   <= activePix;
        capPix[CH_FRONT] <= frontPix;
        capBpp           <= bpp;
        capLanes         <= lanes;
      end
      if (strb.calcBytes) begin
        for (int i = 0; i < NCH; i++) byteReg[i] <= byteNow[i];
        lineBytes <= OUT_W'(lineProd >> 3);
        errReg    <= bppBad || lanesBad || misAlign || tooShort || rgbShort;
      end
      if (strb.calcTotals) begin
        cfgErr <= errReg;
        if (errReg) begin
          syncPayload   <= '0;
          backPayload   <= '0;
          activePayload <= '0;
          frontPayload  <= '0;
          lineLen       <= '0;
          blankPayload  <= '0;
          idleLen       <= '0;
        end else begin
          syncPayload   <= byteReg[CH_SYNC]  - OUT_W'(14);
          backPayload   <= byteReg[CH_BACK]  - OUT_W'(12);
          activePayload <= byteReg[CH_ACT];
          frontPayload  <= byteReg[CH_FRONT] - OUT_W'(6);
          lineLen       <= lineLenNow;
          blankPayload  <= lineBytes - byteReg[CH_SYNC] - OUT_W'(6);
          idleLen       <= lineLenNow - syncCeil;
        end
      end
    end
  end
endmodule

// File: rtl/dsi_htiming_calc.sv
module dsi_htiming_calc
  import htc_pkg::*;
#(
  parameter int PIX_W  = 16,
  parameter int BPP_W  = 6,
  parameter int LANE_W = 3,
  parameter int OUT_W  = PIX_W + 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [PIX_W-1:0]  syncPix,
  input  logic [PIX_W-1:0]  backPix,
  input  logic [PIX_W-1:0]  activePix,
  input  logic [PIX_W-1:0]  frontPix,
  input  logic [BPP_W-1:0]  bpp,
  input  logic [LANE_W-1:0] lanes,
  output logic              busy,
  output logic              done,
  output logic              cfgErr,
  output logic [OUT_W-1:0]  syncPayload,
  output logic [OUT_W-1:0]  backPayload,
  output logic [OUT_W-1:0]  activePayload,
  output logic [OUT_W-1:0]  frontPayload,
  output logic [OUT_W-1:0]  lineLen,
  output logic [OUT_W-1:0]  blankPayload,
  output logic [OUT_W-1:0]  idleLen
);
  htcStrobes_t strb;

  htc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .strb(strb), .busy(busy), .done(done)
  );

  htc_datapath #(.PIX_W(PIX_W), .BPP_W(BPP_W), .LANE_W(LANE_W), .OUT_W(OUT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .syncPix(syncPix), .backPix(backPix), .activePix(activePix), .frontPix(frontPix),
    .bpp(bpp), .lanes(lanes), .cfgErr(cfgErr),
    .syncPayload(syncPayload), .backPayload(backPayload),
    .activePayload(activePayload), .frontPayload(frontPayload),
    .lineLen(lineLen), .blankPayload(blankPayload), .idleLen(idleLen)
  );
endmodule

// File: rtl/htc_chk.sv
module htc_chk #(
  parameter int OUT_W = 20
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             cfgErr,
  input logic [OUT_W-1:0] syncPayload,
  input logic [OUT_W-1:0] backPayload,
  input logic [OUT_W-1:0] activePayload,
  input logic [OUT_W-1:0] frontPayload,
  input logic [OUT_W-1:0] lineLen,
  input logic [OUT_W-1:0] blankPayload,
  input logic [OUT_W-1:0] idleLen
);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN) done |=> !done);
  // R8
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rstN) done |-> $past(busy));
  // R8
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN) (start && !busy) |=> busy);
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable({cfgErr, syncPayload, backPayload, activePayload, frontPayload,
                       lineLen, blankPayload, idleLen}));
  // R7
  err_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |-> ({syncPayload, backPayload, activePayload, frontPayload,
                 lineLen, blankPayload, idleLen} == '0));
  // R4
  idle_le_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgErr |-> (idleLen <= lineLen));
endmodule

bind dsi_htiming_calc htc_chk #(.OUT_W(OUT_W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done), .cfgErr(cfgErr),
  .syncPayload(syncPayload), .backPayload(backPayload), .activePayload(activePayload),
  .frontPayload(frontPayload), .lineLen(lineLen), .blankPayload(blankPayload),
  .idleLen(idleLen)
);

// File: tb/dsi_htiming_calc_tb.sv
`timescale 1ns/1ps
module dsi_htiming_calc_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [15:0] syncPix = '0, backPix = '0, activePix = '0, frontPix = '0;
  logic [5:0]  bpp = '0;
  logic [2:0]  lanes = '0;
  logic        busy, done, cfgErr;
  logic [19:0] syncPayload, backPayload, activePayload, frontPayload;
  logic [19:0] lineLen, blankPayload, idleLen;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  dsi_htiming_calc u_dut (
    .clk(clk), .rstN(rstN), .start(start),
    .syncPix(syncPix), .backPix(backPix), .activePix(activePix), .frontPix(frontPix),
    .bpp(bpp), .lanes(lanes), .busy(busy), .done(done), .cfgErr(cfgErr),
    .syncPayload(syncPayload), .backPayload(backPayload), .activePayload(activePayload),
    .frontPayload(frontPayload), .lineLen(lineLen), .blankPayload(blankPayload),
    .idleLen(idleLen)
  );

  task automatic check(input int act, input int exp, input string tag);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int mCnt = 0;
  int pend[8];   // err, sync, back, act, front, line, blank, idle
  int eOut[8];

  function automatic int cdiv(input int x, input int n);
    return (x + n - 1) / n;
  endfunction

  task automatic computeExp(input int s, input int b, input int a, input int f,
                            input int bp, input int ln);
    int sb, bb, ab, fb, lb, ll;
    bit err;
    sb = s * bp / 8; bb = b * bp / 8; ab = a * bp / 8; fb = f * bp / 8;
    lb = (s + b + a + f) * bp / 8;
    err = !(bp == 16 || bp == 18 || bp == 24 || bp == 30);   // R5
    err |= (ln < 1 || ln > 4);                                 // R5
    err |= ((a * bp) % 32) != 0;                               // R6
    err |= (sb < 14 || bb < 12 || fb < 6);                     // R7
    err |= (bp == 24 && (s < 5 || b < 5 || f < 10));           // R7
    if (err) begin
      pend[0] = 1;
      for (int k = 1; k < 8; k++) pend[k] = 0;
    end else begin
      ll = cdiv(lb, ln);
      pend[0] = 0;
      pend[1] = sb - 14; pend[2] = bb - 12; pend[3] = ab; pend[4] = fb - 6;  // R1
      pend[5] = ll;                                                          // R2
      pend[6] = lb - 20 - (sb - 14);                                         // R3
      pend[7] = ll - cdiv(sb, ln);                                           // R4
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      mCnt = 0;
      for (int k = 0; k < 8; k++) eOut[k] = 0;
    end else if (mCnt == 3) begin
      mCnt = 2;
    end else if (mCnt == 2) begin
      mCnt = 1;
      for (int k = 0; k < 8; k++) eOut[k] = pend[k];
    end else if (start) begin
      mCnt = 3;
      computeExp(syncPix, backPix, activePix, frontPix, bpp, lanes);
    end else begin
      mCnt = 0;
    end
    #5;
    if (!finished) begin
      check(busy,  (mCnt == 3 || mCnt == 2), "R8 busy");
      check(done,  (mCnt == 1), "R8 done");
      check(cfgErr, eOut[0], "R5/R6/R7 cfgErr");
      check(syncPayload,   eOut[1], "R1 syncPayload");
      check(backPayload,   eOut[2], "R1 backPayload");
      check(activePayload, eOut[3], "R1 activePayload");
      check(frontPayload,  eOut[4], "R1 frontPayload");
      check(lineLen,       eOut[5], "R2 lineLen");
      check(blankPayload,  eOut[6], "R3 blankPayload");
      check(idleLen,       eOut[7], "R4 idleLen");
    end
    if (cycles > 20000 && !finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected<=20000 cycles", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic setIn(input int s, input int b, input int a, input int f,
                       input int bp, input int ln);
    syncPix = 16'(s); backPix = 16'(b); activePix = 16'(a); frontPix = 16'(f);
    bpp = 6'(bp); lanes = 3'(ln);
  endtask

  task automatic runCase(input int s, input int b, input int a, input int f,
                         input int bp, input int ln);
    @(negedge clk);
    setIn(s, b, a, f, bp, ln);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check(busy, 0, "R10 busy reset");
    check(lineLen, 0, "R10 lineLen reset");
    rstN = 1'b1;

    // R1 R2 R3 R4 worked example
    runCase(12, 12, 1920, 24, 16, 4);
    check(syncPayload, 10, "R1 example sync");
    check(backPayload, 12, "R1 example back");
    check(activePayload, 3840, "R1 example active");
    check(frontPayload, 42, "R1 example front");
    check(lineLen, 984, "R2 example line");
    check(blankPayload, 3906, "R3 example blank");
    check(idleLen, 978, "R4 example idle");

    runCase(8, 10, 1280, 20, 24, 3);    // three lanes, RGB888
    runCase(10, 9, 1024, 12, 18, 1);    // packed 18 bpp, one lane
    runCase(6, 5, 800, 3, 30, 2);       // 30 bpp, two lanes
    runCase(7, 6, 640, 3, 16, 1);       // R7 boundary: zero payloads legal
    check(cfgErr, 0, "R7 boundary legal");
    check(syncPayload, 0, "R7 boundary zero sync");

    runCase(12, 12, 1920, 24, 20, 4);   // R5 bad bpp
    check(cfgErr, 1, "R5 bpp 20");
    runCase(12, 12, 1920, 24, 16, 0);   // R5 zero lanes
    check(cfgErr, 1, "R5 lanes 0");
    runCase(12, 12, 1920, 24, 16, 5);   // R5 five lanes
    runCase(12, 12, 1919, 24, 16, 4);   // R6 misaligned active
    check(cfgErr, 1, "R6 misaligned");
    runCase(12, 12, 1000, 24, 18, 2);   // R6 18 bpp, not multiple of 16
    runCase(6, 12, 1920, 24, 16, 4);    // R7 sync too short
    check(cfgErr, 1, "R7 short sync");
    runCase(8, 8, 1920, 9, 24, 4);      // R7 RGB888 front porch min
    check(cfgErr, 1, "R7 rgb front 9");
    check(lineLen, 0, "R7 err zeroes line");
    runCase(5, 5, 1920, 10, 24, 4);     // R7 RGB888 minimums exactly
    check(cfgErr, 0, "R7 rgb minimums legal");

    // R9 start while busy ignored; inputs changed after capture ignored (R8)
    @(negedge clk);
    setIn(12, 12, 1920, 24, 16, 4);
    start = 1'b1;
    @(negedge clk);
    setIn(20, 30, 640, 40, 24, 2);
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    check(lineLen, 984, "R9 busy start ignored");
    check(done, 0, "R9 no second done");

    // R9 back-to-back: start sampled in the done cycle is accepted
    @(negedge clk);
    setIn(12, 12, 1920, 24, 16, 2);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    @(negedge clk);
    setIn(12, 12, 1920, 24, 16, 1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    check(lineLen, 3936, "R9 back-to-back second result");

    // R10 reset mid-run
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check(cfgErr, 0, "R10 reset err");
    check(idleLen, 0, "R10 reset idle");
    rstN = 1'b1;
    runCase(16, 16, 960, 32, 24, 4);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule